// File: doc/BRIEF.md
# Asynchronous Receive Parity Checker and Word Formatter

This block sits between an asynchronous receive shifter and a receive FIFO. Each cycle in which the shifter presents a complete character (5 to 8 data bits plus the parity bit it sampled), the block masks the data to the configured length and works out the parity the character should carry. The parity rule is one of four: forced zero, odd, even or forced one. The block compares that expected bit with the received one. One cycle later it issues a single FIFO write made of a data word and a status byte.

Where the received parity bit is kept depends on the configuration. For short characters (5, 6 or 7 bits) it is placed in the data word just above the highest data bit, unless a strip control suppresses it. For 8-bit characters it goes into bit 0 of the status byte when the status-format control is set. A mismatch sets bit 7 of the status byte. It also raises a one-cycle interrupt pulse when the interrupt enable is set. A combinational parity generator for the transmit side uses the same length and mode settings.

Top module: `async_rx_parity_fmt`

## Requirements
- R1: A character presented with `rx_valid` high in cycle N gives `fifo_wr` high in cycle N+1, with exactly one write per character. `fifo_wr` is low in any cycle that follows a cycle without `rx_valid`.
- R2: `cfg_char_len` encodes the data length as 00 = 5, 01 = 6, 10 = 7, 11 = 8 bits. The low bits of `fifo_data` carry `rx_data` up to that length. Bits above the length are 0, unless R7 places the parity bit there.
- R3: In odd mode (`cfg_par_mode` = 01), a parity error is flagged when the masked data bits together with `rx_par_bit` contain an even number of ones.
- R4: In even mode (`cfg_par_mode` = 10), a parity error is flagged when the masked data bits together with `rx_par_bit` contain an odd number of ones.
- R5: In space mode (00) the expected parity bit is 0, and in mark mode (11) it is 1. An error is flagged when `rx_par_bit` differs from that constant.
- R6: A flagged parity error sets bit 7 of `fifo_stat` in the write for that character. Bits 6 to 1 of `fifo_stat` are always 0.
- R7: With parity enabled, a 5, 6 or 7-bit length and `cfg_strip_par` = 0, `rx_par_bit` is written to `fifo_data` bit 5, 6 or 7 (the bit index equals the length). With `cfg_strip_par` = 1 that bit stays 0.
- R8: With parity enabled, an 8-bit length and `cfg_stat_fmt` = 1, `fifo_stat` bit 0 carries `rx_par_bit`. In every other case `fifo_stat` bit 0 is 0.
- R9: With `cfg_par_en` = 0, the value of `rx_par_bit` has no effect. `fifo_stat` is 0, no parity bit appears in `fifo_data`, and `perr_irq` stays low.
- R10: `perr_irq` is high for exactly the cycle of the write that carries a parity error, and only when `cfg_perr_irq_en` = 1.
- R11: `tx_par_bit` is combinational. It gives the parity bit that satisfies the selected mode for `tx_data` masked to the configured length, and it is 0 when parity is disabled.
- R12: While `rst_n` is low, `fifo_wr`, `perr_irq`, `fifo_data` and `fifo_stat` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_par_en | input | 1 | Parity generation and checking enable |
| cfg_par_mode | input | 2 | 00 space, 01 odd, 10 even, 11 mark |
| cfg_char_len | input | 2 | Data length code, 00 = 5 bits to 11 = 8 bits |
| cfg_strip_par | input | 1 | 1 keeps the parity bit out of short-character data words |
| cfg_stat_fmt | input | 1 | 1 puts the parity bit of 8-bit characters into status bit 0 |
| cfg_perr_irq_en | input | 1 | Parity error interrupt enable |
| rx_valid | input | 1 | A received character is present this cycle |
| rx_data | input | 8 | Received data bits, LSB first bit |
| rx_par_bit | input | 1 | Received parity bit |
| fifo_wr | output | 1 | FIFO write strobe, one cycle per character |
| fifo_data | output | 8 | FIFO data word |
| fifo_stat | output | 8 | FIFO status byte |
| perr_irq | output | 1 | Parity error interrupt pulse |
| tx_data | input | 8 | Transmit character data |
| tx_par_bit | output | 1 | Generated transmit parity bit |

## Verification
The bench targets the data bits above the length. A design that masks poorly would leak stale upper bits of `rx_data` into the word. It would also leave them out of, or wrongly add them to, the parity sum. The bench checks the parity placement boundary between 7 and 8 bits. An off-by-one index would put the parity bit in the wrong place, or into the data word of an 8-bit character. With parity disabled, the bench sends a deliberately wrong parity bit to catch a design that still flags errors. It also confirms that the interrupt pulse is one cycle wide and is suppressed when its enable is clear, and that back-to-back characters give consecutive writes.

// File: rtl/rxpar_pkg.sv
package rxpar_pkg;

    typedef enum logic [1:0] {
        PAR_SPACE = 2'b00,
        PAR_ODD   = 2'b01,
        PAR_EVEN  = 2'b10,
        PAR_MARK  = 2'b11
    } par_mode_e;

endpackage

// File: rtl/rxpar_len_mask.sv
module rxpar_len_mask #(
    parameter int DATA_W  = 8,
    parameter int LEN_W   = 2,
    parameter int MIN_LEN = 5
) (
    input  logic [DATA_W-1:0] data_in,
    input  logic [LEN_W-1:0]  len_code,
    output logic [DATA_W-1:0] data_masked
);

    // Keep bit i only when it lies inside the configured character length.
    always_comb begin
        for (int i = 0; i < DATA_W; i++) begin
            data_masked[i] = data_in[i] && (i < (MIN_LEN + int'(len_code)));
        end
    end

endmodule

// File: rtl/rxpar_expect.sv
module rxpar_expect
    import rxpar_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] data_masked,
    input  logic [1:0]        mode,
    output logic              exp_par
);

    always_comb begin
        unique case (par_mode_e'(mode))
            PAR_SPACE: exp_par = 1'b0;
            PAR_ODD:   exp_par = ~(^data_masked);
            PAR_EVEN:  exp_par = ^data_masked;
            PAR_MARK:  exp_par = 1'b1;
            default:   exp_par = 1'b0;
        endcase
    end

endmodule

// File: rtl/rxpar_pack.sv
module rxpar_pack #(
    parameter int DATA_W  = 8,
    parameter int LEN_W   = 2,
    parameter int MIN_LEN = 5,
    parameter int STAT_W  = 8
) (
    input  logic              par_en,
    input  logic [LEN_W-1:0]  len_code,
    input  logic              strip_par,
    input  logic              stat_fmt,
    input  logic [DATA_W-1:0] data_masked,
    input  logic              par_bit,
    input  logic              par_err,
    output logic [DATA_W-1:0] word_out,
    output logic [STAT_W-1:0] stat_out
);

    localparam int ERR_POS = STAT_W - 1;

    int  char_bits;
    logic full_width;

    always_comb begin
        char_bits  = MIN_LEN + int'(len_code);
        full_width = (char_bits >= DATA_W);

        word_out = data_masked;
        for (int i = 0; i < DATA_W; i++) begin
            if (par_en && !strip_par && !full_width && (i == char_bits)) begin
                word_out[i] = par_bit;
            end
        end

        stat_out          = '0;
        stat_out[ERR_POS] = par_en && par_err;
        stat_out[0]       = par_en && full_width && stat_fmt && par_bit;
    end

endmodule

// File: rtl/async_rx_parity_fmt.sv
module async_rx_parity_fmt #(
    parameter int DATA_W  = 8,
    parameter int LEN_W   = 2,
    parameter int MIN_LEN = 5,
    parameter int STAT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_par_en,
    input  logic [1:0]        cfg_par_mode,
    input  logic [LEN_W-1:0]  cfg_char_len,
    input  logic              cfg_strip_par,
    input  logic              cfg_stat_fmt,
    input  logic              cfg_perr_irq_en,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_par_bit,
    output logic              fifo_wr,
    output logic [DATA_W-1:0] fifo_data,
    output logic [STAT_W-1:0] fifo_stat,
    output logic              perr_irq,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_par_bit
);

    localparam int ERR_POS = STAT_W - 1;

    typedef struct packed {
        logic              wr;
        logic [DATA_W-1:0] data;
        logic [STAT_W-1:0] stat;
        logic              irq;
    } out_state_t;

    out_state_t st_d, st_q;

    logic [DATA_W-1:0] rx_masked_d;
    logic              rx_exp_d;
    logic              rx_err_d;
    logic [DATA_W-1:0] rx_word_d;
    logic [STAT_W-1:0] rx_stat_d;
    logic [DATA_W-1:0] tx_masked_d;
    logic              tx_exp_d;

    rxpar_len_mask #(.DATA_W(DATA_W), .LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_rx_mask (
        .data_in     (rx_data),
        .len_code    (cfg_char_len),
        .data_masked (rx_masked_d)
    );

    rxpar_expect #(.DATA_W(DATA_W)) u_rx_expect (
        .data_masked (rx_masked_d),
        .mode        (cfg_par_mode),
        .exp_par     (rx_exp_d)
    );

    assign rx_err_d = cfg_par_en && (rx_par_bit != rx_exp_d);

    rxpar_pack #(.DATA_W(DATA_W), .LEN_W(LEN_W), .MIN_LEN(MIN_LEN), .STAT_W(STAT_W)) u_pack (
        .par_en      (cfg_par_en),
        .len_code    (cfg_char_len),
        .strip_par   (cfg_strip_par),
        .stat_fmt    (cfg_stat_fmt),
        .data_masked (rx_masked_d),
        .par_bit     (rx_par_bit),
        .par_err     (rx_err_d),
        .word_out    (rx_word_d),
        .stat_out    (rx_stat_d)
    );

    rxpar_len_mask #(.DATA_W(DATA_W), .LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_tx_mask (
        .data_in     (tx_data),
        .len_code    (cfg_char_len),
        .data_masked (tx_masked_d)
    );

    rxpar_expect #(.DATA_W(DATA_W)) u_tx_expect (
        .data_masked (tx_masked_d),
        .mode        (cfg_par_mode),
        .exp_par     (tx_exp_d)
    );

    assign tx_par_bit = cfg_par_en && tx_exp_d;

    always_comb begin
        st_d = '0;
        if (rx_valid) begin
            st_d.wr   = 1'b1;
            st_d.data = rx_word_d;
            st_d.stat = rx_stat_d;
            st_d.irq  = rx_err_d && cfg_perr_irq_en;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fifo_wr   = st_q.wr;
    assign fifo_data = st_q.data;
    assign fifo_stat = st_q.stat;
    assign perr_irq  = st_q.irq;

    // One write in the cycle after each presented character
    assert_wr_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> fifo_wr);
    assert_wr_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> !fifo_wr);

    // Interrupt only alongside an error-flagged write
    assert_irq_with_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
        perr_irq |-> (fifo_wr && fifo_stat[ERR_POS]));
    assert_irq_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !cfg_perr_irq_en) |=> !perr_irq);

    // Disabled parity leaves status clear and interrupt idle
    assert_no_parity_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !cfg_par_en) |=> ((fifo_stat == '0) && !perr_irq));

    // Shortest character without parity: upper word bits clear
    assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !cfg_par_en && (cfg_char_len == '0)) |=> (fifo_data[DATA_W-1:MIN_LEN] == '0));

endmodule

// File: tb/async_rx_parity_fmt_bench.sv
module async_rx_parity_fmt_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_par_en = 1'b0;
    logic [1:0] cfg_par_mode = 2'b00;
    logic [1:0] cfg_char_len = 2'b00;
    logic       cfg_strip_par = 1'b0;
    logic       cfg_stat_fmt = 1'b0;
    logic       cfg_perr_irq_en = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       rx_par_bit = 1'b0;
    logic       fifo_wr;
    logic [7:0] fifo_data;
    logic [7:0] fifo_stat;
    logic       perr_irq;
    logic [7:0] tx_data = 8'h00;
    logic       tx_par_bit;

    int applied = 0;
    int miscomp = 0;

    always #5 clk = ~clk;

    async_rx_parity_fmt u_async_rx_parity_fmt (
        .clk             (clk),
        .rst_n           (rst_n),
        .cfg_par_en      (cfg_par_en),
        .cfg_par_mode    (cfg_par_mode),
        .cfg_char_len    (cfg_char_len),
        .cfg_strip_par   (cfg_strip_par),
        .cfg_stat_fmt    (cfg_stat_fmt),
        .cfg_perr_irq_en (cfg_perr_irq_en),
        .rx_valid        (rx_valid),
        .rx_data         (rx_data),
        .rx_par_bit      (rx_par_bit),
        .fifo_wr         (fifo_wr),
        .fifo_data       (fifo_data),
        .fifo_stat       (fifo_stat),
        .perr_irq        (perr_irq),
        .tx_data         (tx_data),
        .tx_par_bit      (tx_par_bit)
    );

    // {en, mode, len, strip, sfmt, irqen, data, par, exp_data, exp_stat, exp_irq}
    localparam int NV = 13;
    localparam logic [33:0] VEC [NV] = '{
        {1'b1, 2'b01, 2'b11, 1'b0, 1'b1, 1'b1, 8'hA5, 1'b1, 8'hA5, 8'h01, 1'b0}, // R3 R8 odd ok
        {1'b1, 2'b01, 2'b11, 1'b0, 1'b1, 1'b1, 8'hA5, 1'b0, 8'hA5, 8'h80, 1'b1}, // R3 R6 odd err
        {1'b1, 2'b10, 2'b00, 1'b0, 1'b0, 1'b1, 8'hFF, 1'b1, 8'h3F, 8'h00, 1'b0}, // R4 R7 R2 len5
        {1'b1, 2'b10, 2'b01, 1'b0, 1'b0, 1'b1, 8'hC3, 1'b1, 8'h43, 8'h80, 1'b1}, // R4 R7 len6 err
        {1'b1, 2'b00, 2'b10, 1'b0, 1'b0, 1'b1, 8'h7F, 1'b0, 8'h7F, 8'h00, 1'b0}, // R5 space ok
        {1'b1, 2'b11, 2'b10, 1'b0, 1'b0, 1'b1, 8'h00, 1'b0, 8'h00, 8'h80, 1'b1}, // R5 mark err
        {1'b1, 2'b11, 2'b10, 1'b0, 1'b0, 1'b1, 8'h00, 1'b1, 8'h80, 8'h00, 1'b0}, // R5 R7 len7
        {1'b0, 2'b01, 2'b11, 1'b0, 1'b1, 1'b1, 8'h3C, 1'b1, 8'h3C, 8'h00, 1'b0}, // R9
        {1'b0, 2'b01, 2'b00, 1'b0, 1'b0, 1'b1, 8'hFF, 1'b1, 8'h1F, 8'h00, 1'b0}, // R9 R2
        {1'b1, 2'b01, 2'b01, 1'b1, 1'b0, 1'b0, 8'h01, 1'b1, 8'h01, 8'h80, 1'b0}, // R7 strip R10 gated
        {1'b1, 2'b01, 2'b11, 1'b0, 1'b0, 1'b1, 8'h00, 1'b0, 8'h00, 8'h80, 1'b1}, // R8 sfmt off
        {1'b1, 2'b10, 2'b11, 1'b0, 1'b0, 1'b0, 8'h81, 1'b1, 8'h81, 8'h80, 1'b0}, // R4 R8 R10
        {1'b1, 2'b01, 2'b11, 1'b0, 1'b1, 1'b1, 8'hFE, 1'b0, 8'hFE, 8'h00, 1'b0}  // R3 R8 par0
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        applied++;
        if (act !== exp) begin
            miscomp++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("  == %0d vectors applied, %0d miscompares ==", applied, miscomp);
        $finish;
    endtask

    task automatic drive_vec(input logic [33:0] v);
        cfg_par_en      = v[33];
        cfg_par_mode    = v[32:31];
        cfg_char_len    = v[30:29];
        cfg_strip_par   = v[28];
        cfg_stat_fmt    = v[27];
        cfg_perr_irq_en = v[26];
        rx_data         = v[25:18];
        rx_par_bit      = v[17];
        rx_valid        = 1'b1;
    endtask

    task automatic tx_chk(input logic en, input logic [1:0] mode, input logic [1:0] len,
                          input logic [7:0] d, input logic exp);
        cfg_par_en   = en;
        cfg_par_mode = mode;
        cfg_char_len = len;
        tx_data      = d;
        #1;
        chk("R11 tx_par_bit", {7'd0, tx_par_bit}, {7'd0, exp});
    endtask

    initial begin
        #2_000_000;
        miscomp++;
        $display("FAIL watchdog actual=running expected=done");
        finish_up();
    end

    initial begin
        // R12 reset state
        rx_valid = 1'b1;
        rx_data  = 8'hFF;
        repeat (3) @(negedge clk);
        chk("R12 fifo_wr", {7'd0, fifo_wr}, 8'h00);
        chk("R12 perr_irq", {7'd0, perr_irq}, 8'h00);
        chk("R12 fifo_data", fifo_data, 8'h00);
        chk("R12 fifo_stat", fifo_stat, 8'h00);
        rx_valid = 1'b0;
        rst_n    = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", {7'd0, fifo_wr}, 8'h00);

        // Table walk
        for (int k = 0; k < NV; k++) begin
            drive_vec(VEC[k]);
            @(negedge clk);
            rx_valid = 1'b0;
            chk("R1 write strobe", {7'd0, fifo_wr}, 8'h01);
            chk("R2 R7 R9 fifo_data", fifo_data, VEC[k][16:9]);
            chk("R3 R4 R5 R6 R8 fifo_stat", fifo_stat, VEC[k][8:1]);
            chk("R10 perr_irq", {7'd0, perr_irq}, {7'd0, VEC[k][0]});
            @(negedge clk);
            chk("R1 single write", {7'd0, fifo_wr}, 8'h00);
            chk("R10 one-cycle pulse", {7'd0, perr_irq}, 8'h00);
        end

        // R1 back-to-back characters
        drive_vec(VEC[0]);
        @(negedge clk);
        drive_vec(VEC[2]);
        chk("R1 b2b first wr", {7'd0, fifo_wr}, 8'h01);
        chk("R1 b2b first data", fifo_data, 8'hA5);
        @(negedge clk);
        rx_valid = 1'b0;
        chk("R1 b2b second wr", {7'd0, fifo_wr}, 8'h01);
        chk("R1 b2b second data", fifo_data, 8'h3F);
        @(negedge clk);
        chk("R1 b2b end", {7'd0, fifo_wr}, 8'h00);

        // R11 transmit parity generator
        tx_chk(1'b1, 2'b01, 2'b00, 8'h07, 1'b0);
        tx_chk(1'b1, 2'b10, 2'b00, 8'h07, 1'b1);
        tx_chk(1'b1, 2'b00, 2'b00, 8'h07, 1'b0);
        tx_chk(1'b1, 2'b11, 2'b00, 8'h07, 1'b1);
        tx_chk(1'b0, 2'b11, 2'b00, 8'h07, 1'b0);
        tx_chk(1'b1, 2'b01, 2'b00, 8'hE0, 1'b1);
        tx_chk(1'b1, 2'b10, 2'b11, 8'h80, 1'b1);

        // R12 reset mid-stream clears outputs
        drive_vec(VEC[1]);
        @(negedge clk);
        rx_valid = 1'b0;
        rst_n    = 1'b0;
        #1;
        chk("R12 async clear wr", {7'd0, fifo_wr}, 8'h00);
        chk("R12 async clear stat", fifo_stat, 8'h00);
        chk("R12 async clear irq", {7'd0, perr_irq}, 8'h00);

        finish_up();
    end

endmodule